// File: doc/BRIEF.md
# Split Software-Reloaded Translation Cache Pair

This block holds two small translation caches side by side, one serving instruction fetches and one serving data accesses. Each cache maps virtual page numbers to physical page numbers. It is two-way set associative with 32 sets and has its own lookup port, which answers in the same cycle with a hit flag, a miss flag and the physical page number.

The block never walks page tables. When a lookup misses, it only raises the miss flag. Software searches the tables held in memory and writes the mapping back through the load port of the cache that missed. There is one load port for the instruction side and one for the data side, and they are independent. Each set keeps a single recency bit that selects which way a load replaces.

A single invalidate port takes a 5-bit set index. In one cycle it clears both ways of that set in both caches, four entries in total. Stepping the index through all 32 values empties both caches. The set index comes from virtual address bits 16:12, counting the least significant bit as bit 0. Bits 31:17 form the tag. Every port carries the page number, which is address bits 31:12, so bits 4:0 of a page number are the set index.

The design has no state machine. Its only sequential state is the per-way valid bits, tags and physical page numbers, plus one recency bit per set.

Top module: `sw_tlb_pair`

## Requirements
- R1: After reset, every entry in both caches is invalid, so every lookup misses. Every recency bit selects way 0, so the first load into any set fills way 0.
- R2: A lookup with its valid input high reports hit=1, miss=0 and the stored physical page number when either way of set vpn[4:0] is valid and holds tag vpn[19:5]. Otherwise it reports hit=0 and miss=1. With the valid input low, hit and miss are both 0.
- R3: The instruction cache and the data cache are independent. A load through one side never creates a hit on the other side.
- R4: A load writes valid, tag and physical page into the way selected by the set's recency bit, then flips that bit. Three loads of distinct tags into one set therefore leave the second and third mappings, and the first one is evicted.
- R5: A hit in way w sets the set's recency bit to the other way, so the entry that was hit survives the next load into that set.
- R6: An invalidate of index k clears both ways of set k in both caches. Every other set keeps its contents.
- R7: If an invalidate and a load name the same set in the same cycle, the invalidate wins and the load is dropped entirely. A load to a different set in that cycle still completes.
- R8: Lookups are combinational. The effect of a load or an invalidate is visible to a lookup in the cycle after the clock edge that samples it, and not before that edge.
- R9: Issuing invalidates for all 32 index values, one per cycle, leaves both caches empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ilk_vld | input | 1 | Instruction-side lookup request |
| ilk_vpn | input | 20 | Instruction-side lookup page number (address bits 31:12) |
| ilk_hit | output | 1 | Instruction-side hit |
| ilk_miss | output | 1 | Instruction-side miss |
| ilk_ppn | output | 20 | Instruction-side physical page number (0 on miss) |
| dlk_vld | input | 1 | Data-side lookup request |
| dlk_vpn | input | 20 | Data-side lookup page number |
| dlk_hit | output | 1 | Data-side hit |
| dlk_miss | output | 1 | Data-side miss |
| dlk_ppn | output | 20 | Data-side physical page number (0 on miss) |
| ild_vld | input | 1 | Instruction-side load strobe |
| ild_vpn | input | 20 | Instruction-side load page number |
| ild_ppn | input | 20 | Instruction-side load physical page number |
| dld_vld | input | 1 | Data-side load strobe |
| dld_vpn | input | 20 | Data-side load page number |
| dld_ppn | input | 20 | Data-side load physical page number |
| inv_vld | input | 1 | Invalidate strobe |
| inv_idx | input | 5 | Set index to clear in both caches |

## Verification
Lookup results are combinational, so the bench drives a lookup on the falling edge and samples it 1 ns later. It removes the request before the next rising edge, so that plain probes leave the recency bits alone. Loads and invalidates take effect at the first rising edge after they are driven. Every check on their effect probes in the low phase after that edge. One probe deliberately samples before the edge, to confirm that a load is not yet visible. Only the recency-update test holds a hitting lookup across a rising edge, and its expected eviction is derived from that one deliberate update.

// File: rtl/sw_tlb_pkg.sv
package sw_tlb_pkg;
    // Default geometry: 20-bit page numbers, 32 sets, 20-bit physical pages
    localparam int unsigned DEF_VPN_W = 20;
    localparam int unsigned DEF_IDX_W = 5;
    localparam int unsigned DEF_PPN_W = 20;
    localparam int unsigned NUM_WAYS  = 2;

    typedef enum logic {
        WAY_A = 1'b0,
        WAY_B = 1'b1
    } way_e;
endpackage

// File: rtl/tlb_way.sv
module tlb_way #(
    parameter int unsigned IDX_W = 5,
    parameter int unsigned TAG_W = 15,
    parameter int unsigned PPN_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [PPN_W-1:0] wr_ppn,
    input  logic             inv_en,
    input  logic [IDX_W-1:0] inv_idx,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_vld,
    output logic [TAG_W-1:0] rd_tag,
    output logic [PPN_W-1:0] rd_ppn
);
    localparam int unsigned SETS = 1 << IDX_W;

    logic [SETS-1:0]  vld_q;
    logic [TAG_W-1:0] tag_q [SETS];
    logic [PPN_W-1:0] ppn_q [SETS];

    // Valid bits: the invalidate is applied last so that it wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else begin
            if (wr_en) begin
                vld_q[wr_idx] <= 1'b1;
            end
            if (inv_en) begin
                vld_q[inv_idx] <= 1'b0;
            end
        end
    end

    // Payload storage needs no reset; it is guarded by the valid bits
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx] <= wr_tag;
            ppn_q[wr_idx] <= wr_ppn;
        end
    end

    always_comb begin
        rd_vld = vld_q[rd_idx];
        rd_tag = tag_q[rd_idx];
        rd_ppn = ppn_q[rd_idx];
    end

    // R6
    inv_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_en |=> !vld_q[$past(inv_idx)]);

    // R4
    wr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !(inv_en && inv_idx == wr_idx)) |=>
            (vld_q[$past(wr_idx)] && tag_q[$past(wr_idx)] == $past(wr_tag)
             && ppn_q[$past(wr_idx)] == $past(wr_ppn)));
endmodule

// File: rtl/tlb_bank.sv
module tlb_bank
    import sw_tlb_pkg::*;
#(
    parameter int unsigned VPN_W = DEF_VPN_W,
    parameter int unsigned IDX_W = DEF_IDX_W,
    parameter int unsigned PPN_W = DEF_PPN_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_vld,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic             lk_miss,
    output logic [PPN_W-1:0] lk_ppn,
    input  logic             ld_vld,
    input  logic [VPN_W-1:0] ld_vpn,
    input  logic [PPN_W-1:0] ld_ppn,
    input  logic             inv_vld,
    input  logic [IDX_W-1:0] inv_idx
);
    localparam int unsigned TAG_W = VPN_W - IDX_W;
    localparam int unsigned SETS  = 1 << IDX_W;

    logic [IDX_W-1:0] lk_idx;
    logic [TAG_W-1:0] lk_tag;
    logic [IDX_W-1:0] ld_idx;
    logic [TAG_W-1:0] ld_tag;
    logic             ld_go;
    way_e             victim;
    logic [SETS-1:0]  lru_q;

    logic [NUM_WAYS-1:0] way_vld;
    logic [NUM_WAYS-1:0] way_hit;
    logic [TAG_W-1:0]    way_tag [NUM_WAYS];
    logic [PPN_W-1:0]    way_ppn [NUM_WAYS];

    assign lk_idx = lk_vpn[IDX_W-1:0];
    assign lk_tag = lk_vpn[VPN_W-1:IDX_W];
    assign ld_idx = ld_vpn[IDX_W-1:0];
    assign ld_tag = ld_vpn[VPN_W-1:IDX_W];

    // An invalidate of the same set drops the load
    assign ld_go  = ld_vld && !(inv_vld && inv_idx == ld_idx);
    assign victim = way_e'(lru_q[ld_idx]);

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
        tlb_way #(
            .IDX_W (IDX_W),
            .TAG_W (TAG_W),
            .PPN_W (PPN_W)
        ) u_way (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (ld_go && (victim == way_e'(w))),
            .wr_idx  (ld_idx),
            .wr_tag  (ld_tag),
            .wr_ppn  (ld_ppn),
            .inv_en  (inv_vld),
            .inv_idx (inv_idx),
            .rd_idx  (lk_idx),
            .rd_vld  (way_vld[w]),
            .rd_tag  (way_tag[w]),
            .rd_ppn  (way_ppn[w])
        );
        assign way_hit[w] = lk_vld && way_vld[w] && (way_tag[w] == lk_tag);
    end

    always_comb begin
        lk_hit  = |way_hit;
        lk_miss = lk_vld && !(|way_hit);
        lk_ppn  = '0;
        if (way_hit[0]) begin
            lk_ppn = way_ppn[0];
        end else if (way_hit[1]) begin
            lk_ppn = way_ppn[1];
        end
    end

    // Recency: a hit points away from the hit way, a load flips the bit (load wins)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lru_q <= '0;
        end else begin
            if (lk_hit) begin
                lru_q[lk_idx] <= way_hit[0];
            end
            if (ld_go) begin
                lru_q[ld_idx] <= ~victim;
            end
        end
    end

    // R4
    lru_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_go |=> lru_q[$past(ld_idx)] != $past(lru_q[ld_idx]));

    // R5
    hit_lru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit && !(ld_go && ld_idx == lk_idx)) |=>
            lru_q[$past(lk_idx)] == $past(way_hit[0]));

    // R7
    drop_keeps_lru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_vld && inv_vld && inv_idx == ld_idx && !(lk_hit && lk_idx == ld_idx))
            |=> lru_q[$past(ld_idx)] == $past(lru_q[ld_idx]));
endmodule

// File: rtl/sw_tlb_pair.sv
module sw_tlb_pair
    import sw_tlb_pkg::*;
#(
    parameter int unsigned VPN_W = DEF_VPN_W,
    parameter int unsigned IDX_W = DEF_IDX_W,
    parameter int unsigned PPN_W = DEF_PPN_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ilk_vld,
    input  logic [VPN_W-1:0] ilk_vpn,
    output logic             ilk_hit,
    output logic             ilk_miss,
    output logic [PPN_W-1:0] ilk_ppn,
    input  logic             dlk_vld,
    input  logic [VPN_W-1:0] dlk_vpn,
    output logic             dlk_hit,
    output logic             dlk_miss,
    output logic [PPN_W-1:0] dlk_ppn,
    input  logic             ild_vld,
    input  logic [VPN_W-1:0] ild_vpn,
    input  logic [PPN_W-1:0] ild_ppn,
    input  logic             dld_vld,
    input  logic [VPN_W-1:0] dld_vpn,
    input  logic [PPN_W-1:0] dld_ppn,
    input  logic             inv_vld,
    input  logic [IDX_W-1:0] inv_idx
);
    tlb_bank #(
        .VPN_W (VPN_W),
        .IDX_W (IDX_W),
        .PPN_W (PPN_W)
    ) u_ibank (
        .clk     (clk),
        .rst_n   (rst_n),
        .lk_vld  (ilk_vld),
        .lk_vpn  (ilk_vpn),
        .lk_hit  (ilk_hit),
        .lk_miss (ilk_miss),
        .lk_ppn  (ilk_ppn),
        .ld_vld  (ild_vld),
        .ld_vpn  (ild_vpn),
        .ld_ppn  (ild_ppn),
        .inv_vld (inv_vld),
        .inv_idx (inv_idx)
    );

    tlb_bank #(
        .VPN_W (VPN_W),
        .IDX_W (IDX_W),
        .PPN_W (PPN_W)
    ) u_dbank (
        .clk     (clk),
        .rst_n   (rst_n),
        .lk_vld  (dlk_vld),
        .lk_vpn  (dlk_vpn),
        .lk_hit  (dlk_hit),
        .lk_miss (dlk_miss),
        .lk_ppn  (dlk_ppn),
        .ld_vld  (dld_vld),
        .ld_vpn  (dld_vpn),
        .ld_ppn  (dld_ppn),
        .inv_vld (inv_vld),
        .inv_idx (inv_idx)
    );

    // R6
    inv_both_sides_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_vld |=> !(ilk_hit && ilk_vpn[IDX_W-1:0] == $past(inv_idx))
                 && !(dlk_hit && dlk_vpn[IDX_W-1:0] == $past(inv_idx)));

    // R2
    lookup_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ilk_vld |-> !(ilk_hit || ilk_miss));
endmodule

// File: tb/sw_tlb_pair_tb.sv
module sw_tlb_pair_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ilk_vld = 1'b0, dlk_vld = 1'b0;
    logic [19:0] ilk_vpn = '0, dlk_vpn = '0;
    logic        ilk_hit, ilk_miss, dlk_hit, dlk_miss;
    logic [19:0] ilk_ppn, dlk_ppn;
    logic        ild_vld = 1'b0, dld_vld = 1'b0;
    logic [19:0] ild_vpn = '0, dld_vpn = '0, ild_ppn = '0, dld_ppn = '0;
    logic        inv_vld = 1'b0;
    logic [4:0]  inv_idx = '0;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    sw_tlb_pair u_dut (
        .clk(clk), .rst_n(rst_n),
        .ilk_vld(ilk_vld), .ilk_vpn(ilk_vpn), .ilk_hit(ilk_hit),
        .ilk_miss(ilk_miss), .ilk_ppn(ilk_ppn),
        .dlk_vld(dlk_vld), .dlk_vpn(dlk_vpn), .dlk_hit(dlk_hit),
        .dlk_miss(dlk_miss), .dlk_ppn(dlk_ppn),
        .ild_vld(ild_vld), .ild_vpn(ild_vpn), .ild_ppn(ild_ppn),
        .dld_vld(dld_vld), .dld_vpn(dld_vpn), .dld_ppn(dld_ppn),
        .inv_vld(inv_vld), .inv_idx(inv_idx)
    );

    function automatic logic [19:0] vpn(input logic [14:0] tag, input logic [4:0] idx);
        return {tag, idx};
    endfunction

    task automatic check(input string rq, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // Drive a lookup in the low phase, sample, release before the rising edge
    task automatic peek(input string rq, input bit dside, input logic [19:0] v,
                        input bit exp_hit, input logic [19:0] exp_ppn);
        @(negedge clk);
        if (dside) begin dlk_vld = 1'b1; dlk_vpn = v; end
        else       begin ilk_vld = 1'b1; ilk_vpn = v; end
        #1;
        if (dside) begin
            check(rq, "d hit", 32'(dlk_hit), 32'(exp_hit));
            check(rq, "d miss", 32'(dlk_miss), 32'(!exp_hit));
            if (exp_hit) check(rq, "d ppn", 32'(dlk_ppn), 32'(exp_ppn));
        end else begin
            check(rq, "i hit", 32'(ilk_hit), 32'(exp_hit));
            check(rq, "i miss", 32'(ilk_miss), 32'(!exp_hit));
            if (exp_hit) check(rq, "i ppn", 32'(ilk_ppn), 32'(exp_ppn));
        end
        #1;
        ilk_vld = 1'b0;
        dlk_vld = 1'b0;
    endtask

    task automatic load(input bit dside, input logic [19:0] v, input logic [19:0] p);
        @(negedge clk);
        if (dside) begin dld_vld = 1'b1; dld_vpn = v; dld_ppn = p; end
        else       begin ild_vld = 1'b1; ild_vpn = v; ild_ppn = p; end
        @(posedge clk);
        #1;
        ild_vld = 1'b0;
        dld_vld = 1'b0;
    endtask

    task automatic invalidate(input logic [4:0] k);
        @(negedge clk);
        inv_vld = 1'b1;
        inv_idx = k;
        @(posedge clk);
        #1;
        inv_vld = 1'b0;
    endtask

    task automatic t_reset;
        for (int k = 0; k < 32; k += 7) begin
            peek("R1", 1'b0, vpn(15'h0, 5'(k)), 1'b0, '0);
            peek("R1", 1'b1, vpn(15'h0, 5'(k)), 1'b0, '0);
        end
        @(negedge clk);
        ilk_vpn = vpn(15'h0, 5'd0);
        dlk_vpn = vpn(15'h0, 5'd0);
        #1;
        check("R2", "idle i hit|miss", 32'(ilk_hit | ilk_miss), 32'd0);
        check("R2", "idle d hit|miss", 32'(dlk_hit | dlk_miss), 32'd0);
    endtask

    task automatic t_basic;
        logic [19:0] a;
        logic [19:0] b;
        a = vpn(15'h0011, 5'd3);
        b = vpn(15'h0022, 5'd3);
        // R8: not visible before the sampling edge, visible right after
        @(negedge clk);
        ild_vld = 1'b1; ild_vpn = a; ild_ppn = 20'hAAAAA;
        ilk_vld = 1'b1; ilk_vpn = a;
        #1;
        check("R8", "pre-edge miss", 32'(ilk_miss), 32'd1);
        @(posedge clk);
        #1;
        ild_vld = 1'b0;
        check("R8", "post-edge hit", 32'(ilk_hit), 32'd1);
        ilk_vld = 1'b0;
        peek("R2", 1'b0, a, 1'b1, 20'hAAAAA);
        peek("R2", 1'b0, vpn(15'h0012, 5'd3), 1'b0, '0);
        peek("R3", 1'b1, a, 1'b0, '0);
        load(1'b1, b, 20'hBBBBB);
        peek("R2", 1'b1, b, 1'b1, 20'hBBBBB);
        peek("R3", 1'b0, b, 1'b0, '0);
    endtask

    task automatic t_replace;
        load(1'b0, vpn(15'h0101, 5'd7), 20'h00001);
        load(1'b0, vpn(15'h0102, 5'd7), 20'h00002);
        load(1'b0, vpn(15'h0103, 5'd7), 20'h00003);
        peek("R4", 1'b0, vpn(15'h0101, 5'd7), 1'b0, '0);
        peek("R4", 1'b0, vpn(15'h0102, 5'd7), 1'b1, 20'h00002);
        peek("R4", 1'b0, vpn(15'h0103, 5'd7), 1'b1, 20'h00003);
    endtask

    task automatic t_hit_lru;
        load(1'b1, vpn(15'h0201, 5'd9), 20'h10001);
        load(1'b1, vpn(15'h0202, 5'd9), 20'h10002);
        // hold a hitting lookup across one rising edge
        @(negedge clk);
        dlk_vld = 1'b1; dlk_vpn = vpn(15'h0201, 5'd9);
        #1;
        check("R5", "touch hit", 32'(dlk_hit), 32'd1);
        @(posedge clk);
        #1;
        dlk_vld = 1'b0;
        load(1'b1, vpn(15'h0203, 5'd9), 20'h10003);
        peek("R5", 1'b1, vpn(15'h0201, 5'd9), 1'b1, 20'h10001);
        peek("R5", 1'b1, vpn(15'h0202, 5'd9), 1'b0, '0);
        peek("R5", 1'b1, vpn(15'h0203, 5'd9), 1'b1, 20'h10003);
    endtask

    task automatic t_invalidate;
        load(1'b0, vpn(15'h0301, 5'd12), 20'h20001);
        load(1'b0, vpn(15'h0302, 5'd12), 20'h20002);
        load(1'b1, vpn(15'h0303, 5'd12), 20'h20003);
        load(1'b1, vpn(15'h0304, 5'd12), 20'h20004);
        load(1'b0, vpn(15'h0305, 5'd13), 20'h20005);
        load(1'b1, vpn(15'h0306, 5'd13), 20'h20006);
        invalidate(5'd12);
        peek("R6", 1'b0, vpn(15'h0301, 5'd12), 1'b0, '0);
        peek("R6", 1'b0, vpn(15'h0302, 5'd12), 1'b0, '0);
        peek("R6", 1'b1, vpn(15'h0303, 5'd12), 1'b0, '0);
        peek("R6", 1'b1, vpn(15'h0304, 5'd12), 1'b0, '0);
        peek("R6", 1'b0, vpn(15'h0305, 5'd13), 1'b1, 20'h20005);
        peek("R6", 1'b1, vpn(15'h0306, 5'd13), 1'b1, 20'h20006);
    endtask

    task automatic t_priority;
        @(negedge clk);
        inv_vld = 1'b1; inv_idx = 5'd20;
        ild_vld = 1'b1; ild_vpn = vpn(15'h0401, 5'd20); ild_ppn = 20'h30001;
        dld_vld = 1'b1; dld_vpn = vpn(15'h0402, 5'd21); dld_ppn = 20'h30002;
        @(posedge clk);
        #1;
        inv_vld = 1'b0; ild_vld = 1'b0; dld_vld = 1'b0;
        peek("R7", 1'b0, vpn(15'h0401, 5'd20), 1'b0, '0);
        peek("R7", 1'b1, vpn(15'h0402, 5'd21), 1'b1, 20'h30002);
    endtask

    task automatic t_sweep;
        load(1'b0, vpn(15'h0501, 5'd0), 20'h40001);
        load(1'b1, vpn(15'h0502, 5'd31), 20'h40002);
        load(1'b0, vpn(15'h0503, 5'd5), 20'h40003);
        peek("R9", 1'b1, vpn(15'h0502, 5'd31), 1'b1, 20'h40002);
        for (int k = 0; k < 32; k++) invalidate(5'(k));
        peek("R9", 1'b0, vpn(15'h0501, 5'd0), 1'b0, '0);
        peek("R9", 1'b1, vpn(15'h0502, 5'd31), 1'b0, '0);
        peek("R9", 1'b0, vpn(15'h0503, 5'd5), 1'b0, '0);
        peek("R9", 1'b1, vpn(15'h0306, 5'd13), 1'b0, '0);
        peek("R9", 1'b1, vpn(15'h0402, 5'd21), 1'b0, '0);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1;
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_replace();
        t_hit_lru();
        t_invalidate();
        t_priority();
        t_sweep();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule